// File: doc/BRIEF.md
# Serial port control and status registers

This block is the register front end of a serial port. A word-indexed bus port gives 32-bit access to 16-bit control registers, two status registers and a handful of configuration registers. The transmitter, the receive FIFO and the receive ageing timer report events through single-cycle strobes. The block keeps sticky flags for those events and exports the control fields that the datapath needs: the receive trigger level and the receive, transmit and ageing enables.

Each interrupt source is gated by an enable bit. Most enables sit at the same bit position as their source, in a paired control register. All gated sources are ORed onto one level-sensitive interrupt line. Writing the second control register with its bit 0 low restarts the whole block and gives a one-cycle pulse to the datapath.

The baud generator and modem lines are not part of this block. Their registers only store 16-bit values and read them back.

Top module: `sio_regs`

## Requirements
- R1: After rst_ni the block reads as follows: status 1 (index 0x25) = 0x2000, status 2 (0x26) = 0x4008, test (0x2D) = 0x0060, baud count (0x2B) = 0x0004, FIFO control (0x24) = 0x0801, control 2 (0x21) = 0x0001, control 3 (0x22) = 0x0700. Every other register reads 0 and irq_o is low.
- R2: The registers at indices 0x20, 0x22, 0x23, 0x24, 0x29, 0x2A, 0x2B and 0x2C store the low 16 bits of a write and read them back with bits 31:16 at zero.
- R3: A read of an unmapped index returns 0, and a write to it changes nothing. The test register is read-only.
- R4: Writing control 2 with bit 0 = 0 returns every other register and status flag to its R1 value. Control 2 then holds the written low 16 bits with bit 0 forced to 1, and soft_rst_o pulses during that write.
- R5: A write to index 0x10 while control 2 bit 2 is set pulses tx_wr_o with the low byte on tx_data_o. It also clears status 1 bit 13, status 2 bit 3, status 2 bit 14 and test bit 6 until tx_done_i pulses. While control 2 bit 2 is clear, the write is ignored.
- R6: Status 1 bit 9 reads 1 when rx_level_i is nonzero and at least FIFO control bits 5:0. Status 2 bit 0 reads 1 when rx_level_i is nonzero. Test bit 5 reads 1 when rx_level_i is zero.
- R7: A read of index 0 with rx_level_i nonzero returns bit 15 set and rx_data_i in bits 7:0, and pulses rx_pop_o. With the FIFO empty, the read returns 0 and gives no pop.
- R8: Writing 1 clears status 1 bit 8 and status 2 bits 1, 2 and 7. Zeros and all other bits have no effect. An event that lands in the same cycle as its clear wins.
- R9: age_tmo_i sets status 1 bit 8, rx_ovf_i sets status 2 bit 1, rx_brk_i sets status 2 bit 2, and rx_push_i sets status 2 bit 7.
- R10: irq_o is high while status 1 bit 13 or bit 9 is set together with the same bit of control 1.
- R11: Status 1 bit 8 drives irq_o only while control 2 bit 3 is set.
- R12: Status 2 bit 14 drives irq_o only while control 1 bit 6 is set.
- R13: Control 4 bits 0, 1, 3 and 7 enable the status 2 bits at the same positions onto irq_o.
- R14: trig_lvl_o carries FIFO control bits 5:0. rx_en_o, tx_en_o and age_en_o carry control 2 bits 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| tx_wr_o | output | 1 | Character handed to the transmitter |
| tx_data_o | output | 8 | Character to send |
| tx_done_i | input | 1 | Transmitter finished the character |
| rx_data_i | input | 8 | Character at the receive FIFO head |
| rx_level_i | input | 6 | Receive FIFO fill level |
| rx_pop_o | output | 1 | Pop the receive FIFO head |
| rx_push_i | input | 1 | Character entered the receive FIFO |
| rx_ovf_i | input | 1 | Receive overrun event |
| rx_brk_i | input | 1 | Break received |
| age_tmo_i | input | 1 | Receive ageing timer expired |
| soft_rst_o | output | 1 | Software reset pulse |
| trig_lvl_o | output | 6 | Receive trigger level |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| age_en_o | output | 1 | Ageing interrupt enable |
| irq_o | output | 1 | Interrupt, level sensitive |

## Verification
The bench builds the block with its default parameters: 16-bit registers, a 32-bit bus and a 6-bit level field. With these widths the truncation of the upper write halves can be observed. They also let trigger levels of 1 and 3 be compared against a FIFO level of 2, so the receive-ready flag is seen both set and clear. The 6-bit index covers the unmapped holes between the decoded registers, and the same-cycle race between an overrun event and its clear can be reached directly.

// File: rtl/sio_regs_pkg.sv
package sio_regs_pkg;
  localparam int IDX_W  = 6;
  localparam int N_CFG  = 8;

  localparam logic [IDX_W-1:0] IX_RXD  = 6'h00;
  localparam logic [IDX_W-1:0] IX_TXD  = 6'h10;
  localparam logic [IDX_W-1:0] IX_CR2  = 6'h21;
  localparam logic [IDX_W-1:0] IX_SR1  = 6'h25;
  localparam logic [IDX_W-1:0] IX_SR2  = 6'h26;
  localparam logic [IDX_W-1:0] IX_TST  = 6'h2d;

  // plain storage: ctl1, ctl3, ctl4, fifo ctl, baud inc, baud mod, baud cnt, ms
  localparam logic [IDX_W-1:0] CFG_IDX [N_CFG] =
    '{6'h20, 6'h22, 6'h23, 6'h24, 6'h29, 6'h2a, 6'h2b, 6'h2c};
  localparam int CFG_CR1 = 0;
  localparam int CFG_CR4 = 2;
  localparam int CFG_FCR = 3;
  localparam logic [N_CFG*16-1:0] CFG_RST =
    {16'h0000, 16'h0004, 16'h0000, 16'h0000, 16'h0801, 16'h0000, 16'h0700, 16'h0000};

  // bit positions shared by status and enable registers
  localparam int B1_TXRDY = 13;
  localparam int B1_RXRDY = 9;
  localparam int B1_AGE   = 8;
  localparam int C1_TXEEN = 6;
  localparam int C2_NRST  = 0;
  localparam int C2_RXEN  = 1;
  localparam int C2_TXEN  = 2;
  localparam int C2_AGEN  = 3;
  localparam int B2_DRDY  = 0;
  localparam int B2_OVR   = 1;
  localparam int B2_BRK   = 2;
  localparam int B2_TXDN  = 3;
  localparam int B2_WAKE  = 7;
  localparam int B2_TXFE  = 14;
  localparam int TS_RXE   = 5;
  localparam int TS_TXE   = 6;

  typedef struct packed {
    logic age;
    logic ovr;
    logic brk;
    logic wake;
    logic busy;
  } sts_t;
endpackage

// File: rtl/sio_regs_cfg.sv
module sio_regs_cfg #(
  parameter int N   = 8,
  parameter int W   = 16,
  parameter logic [N*W-1:0] RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic [N-1:0]      we_i,
  input  logic [W-1:0]      wdata_i,
  output logic [N-1:0][W-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         q_o[i] <= RST[i*W +: W];
      else if (soft_rst_i) q_o[i] <= RST[i*W +: W];
      else if (we_i[i])    q_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/sio_regs_status.sv
module sio_regs_status
  import sio_regs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic tx_start_i,
  input  logic tx_done_i,
  input  logic age_set_i,
  input  logic ovr_set_i,
  input  logic brk_set_i,
  input  logic wake_set_i,
  input  logic age_clr_i,
  input  logic ovr_clr_i,
  input  logic brk_clr_i,
  input  logic wake_clr_i,
  output sts_t sts_o
);
  sts_t nxt;

  // event set has priority over a write-1 clear in the same cycle
  always_comb begin
    nxt = sts_o;
    if (age_clr_i)  nxt.age  = 1'b0;
    if (ovr_clr_i)  nxt.ovr  = 1'b0;
    if (brk_clr_i)  nxt.brk  = 1'b0;
    if (wake_clr_i) nxt.wake = 1'b0;
    if (age_set_i)  nxt.age  = 1'b1;
    if (ovr_set_i)  nxt.ovr  = 1'b1;
    if (brk_set_i)  nxt.brk  = 1'b1;
    if (wake_set_i) nxt.wake = 1'b1;
    if (tx_done_i)  nxt.busy = 1'b0;
    if (tx_start_i) nxt.busy = 1'b1;
    if (soft_rst_i) nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= nxt;
  end
endmodule

// File: rtl/sio_regs_irq.sv
module sio_regs_irq
  import sio_regs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] sr1_i,
  input  logic [W-1:0] sr2_i,
  input  logic [W-1:0] cr1_i,
  input  logic [W-1:0] cr4_i,
  input  logic         age_en_i,
  output logic         irq_o
);
  localparam logic [W-1:0] M1  = W'((1 << B1_TXRDY) | (1 << B1_RXRDY));
  localparam logic [W-1:0] M24 = W'((1 << B2_DRDY) | (1 << B2_OVR) | (1 << B2_TXDN) | (1 << B2_WAKE));

  logic src1, src_age, src_txfe, src2;

  always_comb begin
    src1     = |(sr1_i & cr1_i & M1);
    src_age  = sr1_i[B1_AGE] & age_en_i;
    src_txfe = sr2_i[B2_TXFE] & cr1_i[C1_TXEEN];
    src2     = |(sr2_i & cr4_i & M24);
    irq_o    = src1 | src_age | src_txfe | src2;
  end
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tx_wr_o,
  output logic [CHAR_W-1:0] tx_data_o,
  input  logic              tx_done_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              rx_pop_o,
  input  logic              rx_push_i,
  input  logic              rx_ovf_i,
  input  logic              rx_brk_i,
  input  logic              age_tmo_i,
  output logic              soft_rst_o,
  output logic [LVL_W-1:0]  trig_lvl_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              age_en_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - REG_W;

  logic                        wr, rd;
  logic [REG_W-1:0]            wd;
  logic [N_CFG-1:0]            cfg_we;
  logic [N_CFG-1:0][REG_W-1:0] cfg_q;
  logic [REG_W-1:0]            cr1_q, cr2_q, cr4_q, fcr_q;
  logic [REG_W-1:0]            sr1, sr2, tst;
  logic                        rx_nonempty, rx_rdy;
  sts_t                        sts_q;
  logic                        unused_hi;

  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign wd        = wdata_i[REG_W-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:REG_W];

  assign soft_rst_o = wr & (addr_i == IX_CR2) & ~wd[C2_NRST];

  for (genvar i = 0; i < N_CFG; i++) begin : g_we
    assign cfg_we[i] = wr & (addr_i == CFG_IDX[i]);
  end

  sio_regs_cfg #(.N(N_CFG), .W(REG_W), .RST(CFG_RST)) u_cfg (
    .clk_i, .rst_ni,
    .soft_rst_i (soft_rst_o),
    .we_i       (cfg_we),
    .wdata_i    (wd),
    .q_o        (cfg_q)
  );

  assign cr1_q = cfg_q[CFG_CR1];
  assign cr4_q = cfg_q[CFG_CR4];
  assign fcr_q = cfg_q[CFG_FCR];

  // control 2 keeps the written value, reset bit always reads 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cr2_q <= REG_W'(1);
    else if (wr && addr_i == IX_CR2)   cr2_q <= wd | REG_W'(1);
  end

  assign tx_en_o    = cr2_q[C2_TXEN];
  assign rx_en_o    = cr2_q[C2_RXEN];
  assign age_en_o   = cr2_q[C2_AGEN];
  assign trig_lvl_o = fcr_q[LVL_W-1:0];

  assign tx_wr_o   = wr & (addr_i == IX_TXD) & tx_en_o;
  assign tx_data_o = wdata_i[CHAR_W-1:0];

  logic wr_sr1, wr_sr2;
  assign wr_sr1 = wr & (addr_i == IX_SR1);
  assign wr_sr2 = wr & (addr_i == IX_SR2);

  sio_regs_status u_sts (
    .clk_i, .rst_ni,
    .soft_rst_i (soft_rst_o),
    .tx_start_i (tx_wr_o),
    .tx_done_i,
    .age_set_i  (age_tmo_i),
    .ovr_set_i  (rx_ovf_i),
    .brk_set_i  (rx_brk_i),
    .wake_set_i (rx_push_i),
    .age_clr_i  (wr_sr1 & wd[B1_AGE]),
    .ovr_clr_i  (wr_sr2 & wd[B2_OVR]),
    .brk_clr_i  (wr_sr2 & wd[B2_BRK]),
    .wake_clr_i (wr_sr2 & wd[B2_WAKE]),
    .sts_o      (sts_q)
  );

  assign rx_nonempty = |rx_level_i;
  assign rx_rdy      = rx_nonempty & (rx_level_i >= trig_lvl_o);
  assign rx_pop_o    = rd & (addr_i == IX_RXD) & rx_nonempty;

  always_comb begin
    sr1 = '0;
    sr1[B1_TXRDY] = ~sts_q.busy;
    sr1[B1_RXRDY] = rx_rdy;
    sr1[B1_AGE]   = sts_q.age;
    sr2 = '0;
    sr2[B2_DRDY]  = rx_nonempty;
    sr2[B2_OVR]   = sts_q.ovr;
    sr2[B2_BRK]   = sts_q.brk;
    sr2[B2_TXDN]  = ~sts_q.busy;
    sr2[B2_WAKE]  = sts_q.wake;
    sr2[B2_TXFE]  = ~sts_q.busy;
    tst = '0;
    tst[TS_RXE]   = ~rx_nonempty;
    tst[TS_TXE]   = ~sts_q.busy;
  end

  sio_regs_irq #(.W(REG_W)) u_irq (
    .sr1_i    (sr1),
    .sr2_i    (sr2),
    .cr1_i    (cr1_q),
    .cr4_i    (cr4_q),
    .age_en_i (age_en_o),
    .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == IX_RXD && rx_nonempty) begin
      rdata_o[REG_W-1]    = 1'b1;
      rdata_o[CHAR_W-1:0] = rx_data_i;
    end
    if (addr_i == IX_CR2) rdata_o = {{PAD_W{1'b0}}, cr2_q};
    if (addr_i == IX_SR1) rdata_o = {{PAD_W{1'b0}}, sr1};
    if (addr_i == IX_SR2) rdata_o = {{PAD_W{1'b0}}, sr2};
    if (addr_i == IX_TST) rdata_o = {{PAD_W{1'b0}}, tst};
    for (int i = 0; i < N_CFG; i++)
      if (addr_i == CFG_IDX[i]) rdata_o = {{PAD_W{1'b0}}, cfg_q[i]};
  end
endmodule

// File: rtl/sio_regs_chk.sv
module sio_regs_chk
  import sio_regs_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int LVL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             soft_rst_o,
  input logic             tx_wr_o,
  input logic             tx_en_o,
  input logic             rx_pop_o,
  input logic [LVL_W-1:0] rx_level_i,
  input logic             rx_ovf_i,
  input logic             irq_o,
  input logic [REG_W-1:0] cr1_q,
  input logic [REG_W-1:0] cr2_q,
  input sts_t             sts_q
);
  a_r4_soft_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (cr1_q == '0 && !sts_q.ovr && !sts_q.busy));

  a_r5_tx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_o |-> tx_en_o);

  a_r5_busy_after_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_o |=> sts_q.busy);

  a_r7_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> (rx_level_i != '0));

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_i && !soft_rst_o) |=> sts_q.ovr);

  a_r10_txrdy_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_q.busy && cr1_q[B1_TXRDY]) |-> irq_o);

  a_r11_age_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q.age && cr2_q[C2_AGEN]) |-> irq_o);
endmodule

bind sio_regs sio_regs_chk #(.REG_W(REG_W), .LVL_W(LVL_W)) u_chk (
  .clk_i, .rst_ni, .soft_rst_o, .tx_wr_o, .tx_en_o, .rx_pop_o,
  .rx_level_i, .rx_ovf_i, .irq_o, .cr1_q, .cr2_q, .sts_q
);

// File: tb/sio_regs_tb_top.sv
module sio_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        tx_wr_o, tx_done_i = 0, rx_pop_o, rx_push_i = 0;
  logic [7:0]  tx_data_o, rx_data_i = '0;
  logic [5:0]  rx_level_i = '0, trig_lvl_o;
  logic        rx_ovf_i = 0, rx_brk_i = 0, age_tmo_i = 0;
  logic        soft_rst_o, rx_en_o, tx_en_o, age_en_o, irq_o;

  int n_chk = 0, n_err = 0;
  logic cap_soft, cap_tx, cap_pop;
  logic [7:0] cap_txd;
  logic [31:0] d;

  always #5 clk_i = ~clk_i;

  sio_regs dut_i (.*);

  typedef struct packed {
    logic        we;
    logic [5:0]  idx;
    logic [31:0] dat;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'h20, 32'hFFFF_2040, 32'h0}, '{1'b0, 6'h20, 32'h0, 32'h0000_2040},
    '{1'b1, 6'h22, 32'h1234_5678, 32'h0}, '{1'b0, 6'h22, 32'h0, 32'h0000_5678},
    '{1'b1, 6'h23, 32'hABCD_0089, 32'h0}, '{1'b0, 6'h23, 32'h0, 32'h0000_0089},
    '{1'b1, 6'h24, 32'h0000_0803, 32'h0}, '{1'b0, 6'h24, 32'h0, 32'h0000_0803},
    '{1'b1, 6'h2a, 32'h9999_55AA, 32'h0}, '{1'b0, 6'h2a, 32'h0, 32'h0000_55AA},
    '{1'b1, 6'h2b, 32'h0000_0010, 32'h0}, '{1'b0, 6'h2b, 32'h0, 32'h0000_0010},
    '{1'b1, 6'h2c, 32'h0000_03E8, 32'h0}, '{1'b0, 6'h2c, 32'h0, 32'h0000_03E8},
    '{1'b1, 6'h29, 32'h0000_0077, 32'h0}, '{1'b0, 6'h29, 32'h0, 32'h0000_0077},
    '{1'b1, 6'h3f, 32'hFFFF_FFFF, 32'h0}, '{1'b0, 6'h3f, 32'h0, 32'h0000_0000},
    '{1'b1, 6'h2d, 32'h0000_FFFF, 32'h0}, '{1'b0, 6'h2d, 32'h0, 32'h0000_0060}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic [31:0] dat);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = idx; wdata_i = dat;
    #1 cap_soft = soft_rst_o; cap_tx = tx_wr_o; cap_txd = tx_data_o;
    @(posedge clk_i); #1 req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [5:0] idx, output logic [31:0] v);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = idx;
    #1 v = rdata_o; cap_pop = rx_pop_o;
    @(posedge clk_i); #1 req_i = 0;
  endtask

  task automatic rchk(input string req, input logic [5:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    chk(req, v, exp);
  endtask

  task automatic ichk(input string req, input logic exp);
    @(negedge clk_i); #1 chk(req, {31'b0, irq_o}, {31'b0, exp});
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_i); s = 1'b1;
    @(negedge clk_i); s = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset values
    rchk("R1 sr1", 6'h25, 32'h2000);
    rchk("R1 sr2", 6'h26, 32'h4008);
    rchk("R1 tst", 6'h2d, 32'h0060);
    rchk("R1 bcnt", 6'h2b, 32'h0004);
    rchk("R1 fcr", 6'h24, 32'h0801);
    rchk("R1 cr2", 6'h21, 32'h0001);
    rchk("R1 cr3", 6'h22, 32'h0700);
    rchk("R1 cr4", 6'h23, 32'h0000);
    ichk("R1 irq", 1'b0);

    // R2 storage, R3 unmapped / read-only test register
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].idx, VEC[i].dat);
      else rchk("R2_R3 table", VEC[i].idx, VEC[i].exp);
    end

    // R4 soft reset
    wr(6'h21, 32'h0000_0004);
    chk("R4 pulse", {31'b0, cap_soft}, 32'h1);
    rchk("R4 cr1", 6'h20, 32'h0);
    rchk("R4 cr2", 6'h21, 32'h0005);
    rchk("R4 cr4", 6'h23, 32'h0);
    rchk("R4 fcr", 6'h24, 32'h0801);
    rchk("R4 bcnt", 6'h2b, 32'h0004);
    chk("R14 tx_en", {31'b0, tx_en_o}, 32'h1);

    // R5 transmit
    wr(6'h10, 32'h0000_0141);
    chk("R5 strobe", {31'b0, cap_tx}, 32'h1);
    chk("R5 data", {24'b0, cap_txd}, 32'h41);
    rchk("R5 sr1 busy", 6'h25, 32'h0000);
    rchk("R5 sr2 busy", 6'h26, 32'h0000);
    rchk("R5 tst busy", 6'h2d, 32'h0020);
    pulse(tx_done_i);
    rchk("R5 sr1 done", 6'h25, 32'h2000);
    rchk("R5 sr2 done", 6'h26, 32'h4008);
    wr(6'h21, 32'h0000_0001);
    wr(6'h10, 32'h0000_0055);
    chk("R5 disabled", {31'b0, cap_tx}, 32'h0);
    rchk("R5 sr1 idle", 6'h25, 32'h2000);

    // R10 R12 R13 interrupt gating
    wr(6'h20, 32'h2000); ichk("R10 txrdy", 1'b1);
    wr(6'h20, 32'h0000); ichk("R10 off", 1'b0);
    wr(6'h20, 32'h0040); ichk("R12 txfe", 1'b1);
    wr(6'h20, 32'h0000);
    wr(6'h23, 32'h0008); ichk("R13 txdone", 1'b1);
    wr(6'h23, 32'h0000); ichk("R13 off", 1'b0);

    // R6 receive status from level
    @(negedge clk_i); rx_level_i = 6'd2; rx_data_i = 8'h5A;
    rchk("R6 sr1 rxrdy", 6'h25, 32'h2200);
    rchk("R6 sr2 drdy", 6'h26, 32'h4009);
    rchk("R6 tst", 6'h2d, 32'h0040);
    wr(6'h20, 32'h0200); ichk("R10 rxrdy", 1'b1);
    wr(6'h24, 32'h0803);
    chk("R14 trig", {26'b0, trig_lvl_o}, 32'd3);
    rchk("R6 below trig", 6'h25, 32'h2000);
    ichk("R10 below trig", 1'b0);
    wr(6'h20, 32'h0000);
    wr(6'h23, 32'h0001); ichk("R13 drdy", 1'b1);
    wr(6'h23, 32'h0000);

    // R7 receive data read
    rd(6'h00, d);
    chk("R7 data", d, 32'h0000_805A);
    chk("R7 pop", {31'b0, cap_pop}, 32'h1);
    @(negedge clk_i); rx_level_i = 6'd0;
    rd(6'h00, d);
    chk("R7 empty", d, 32'h0);
    chk("R7 no pop", {31'b0, cap_pop}, 32'h0);

    // R9 R11 R8 ageing flag
    pulse(age_tmo_i);
    rchk("R9 age", 6'h25, 32'h2100);
    ichk("R11 gated", 1'b0);
    wr(6'h21, 32'h0009);
    chk("R14 age_en", {31'b0, age_en_o}, 32'h1);
    ichk("R11 enabled", 1'b1);
    wr(6'h25, 32'h2000); rchk("R8 non-clearable", 6'h25, 32'h2100);
    wr(6'h25, 32'h0000); rchk("R8 zero", 6'h25, 32'h2100);
    wr(6'h25, 32'h0100); rchk("R8 clear age", 6'h25, 32'h2000);
    ichk("R11 cleared", 1'b0);

    // overrun
    pulse(rx_ovf_i);
    rchk("R9 ovr", 6'h26, 32'h400A);
    wr(6'h23, 32'h0002); ichk("R13 ovr", 1'b1);
    wr(6'h26, 32'h0009); rchk("R8 sr2 non-clearable", 6'h26, 32'h400A);
    wr(6'h26, 32'h0002); rchk("R8 clear ovr", 6'h26, 32'h4008);
    ichk("R13 ovr off", 1'b0);

    // set wins over clear
    pulse(rx_ovf_i);
    @(negedge clk_i);
    rx_ovf_i = 1; req_i = 1; we_i = 1; addr_i = 6'h26; wdata_i = 32'h2;
    @(negedge clk_i);
    rx_ovf_i = 0; req_i = 0; we_i = 0;
    rchk("R8 set wins", 6'h26, 32'h400A);
    wr(6'h26, 32'h0002);

    // wake and break
    pulse(rx_push_i);
    rchk("R9 wake", 6'h26, 32'h4088);
    wr(6'h23, 32'h0080); ichk("R13 wake", 1'b1);
    wr(6'h26, 32'h0080); rchk("R8 clear wake", 6'h26, 32'h4008);
    pulse(rx_brk_i);
    rchk("R9 brk", 6'h26, 32'h400C);
    wr(6'h26, 32'h0004); rchk("R8 clear brk", 6'h26, 32'h4008);

    // R4 soft reset clears status
    pulse(rx_ovf_i);
    wr(6'h21, 32'h0000_0000);
    rchk("R4 sr2", 6'h26, 32'h4008);
    rchk("R4 cr2 forced", 6'h21, 32'h0001);
    rchk("R4 cr4 again", 6'h23, 32'h0000);
    chk("R14 rx_en", {31'b0, rx_en_o}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule